// File: doc/BRIEF.md
# Key-Matrix GPIO Port Bank

This block holds four 4-bit general-purpose ports built for scanning a key matrix. The first port only takes input. The second port chooses input or output for each bit on its own. The third and fourth ports each choose one direction for the whole nibble. A processor reaches the port data through a data-memory bus, where the bank select must be zero, and reaches the direction settings through a separate register-file bus. Both buses have a write strobe and a combinational read path.

The block does not drive a pad directly. Each pin has three signals. The first is a pin input level. The second is a drive-low enable, which gives open-drain behaviour: the pin is pulled low for a latch value of 0 and left floating for a 1. The third is a pull-up enable, which is on whenever the pin is an input. While the system is in standby, a low level on any pin that is an input raises a wake request. That request stays up until standby is released. Pin inputs pass through a two-flop synchroniser before they are used by reads or by wake detection.

Top module: `keymx_port_bank`

## Requirements
- R1: The input-only port is read at data address 0x70 of bank 0. Its drive-low enables are always 0 and its pull-up enables are always 1. A write to 0x70 changes no output.
- R2: The data latches of the second, third and fourth ports are written at bank-0 addresses 0x71, 0x72 and 0x73. A write with a nonzero bank select, or to any other address, changes no latch.
- R3: Register-file address 0x26 holds the 4-bit per-bit direction of the second port, where 1 means output. It reads back the value last written.
- R4: At register-file address 0x37, bit 2 sets the direction of the third port and bit 3 sets the direction of the fourth port, where 1 means output. A read of 0x37 returns those two bits in place, with every other bit 0. Any other register-file address reads 0.
- R5: A pin in output mode asserts drive-low exactly when its latch bit is 0. A pin in input mode never asserts drive-low. Both take effect on the clock edge that registers the write.
- R6: A pin's pull-up enable is 1 in input mode and 0 in output mode.
- R7: A data read of a bit in output mode returns the latch bit.
- R8: After reset the second port is all input and its latch is 0. The third and fourth ports are output with cleared latches, so those 8 pins drive low.
- R9: A data read of a bit in input mode returns the pin level delayed by two rising clock edges.
- R10: While standby is 1, wake_req is 1 if any input-mode pin is low after synchronisation. Once raised, it stays 1 for as long as standby remains 1. When standby is 0, wake_req is 0 at once.
- R11: A data write updates the latch even when the bit is in input mode. The stored value drives the pin as soon as output mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dm_bank | input | BANK_W | Data-memory bank select |
| dm_addr | input | DM_AW | Data-memory address |
| dm_wr | input | 1 | Data-memory write strobe |
| dm_wdata | input | NIB | Data-memory write value |
| dm_rdata | output | NIB | Data-memory read value (combinational) |
| rf_addr | input | RF_AW | Register-file address |
| rf_wr | input | 1 | Register-file write strobe |
| rf_wdata | input | NIB | Register-file write value |
| rf_rdata | output | NIB | Register-file read value (combinational) |
| pin_in | input | 4*NIB | Pin levels, one nibble per port, the input-only port at bits 3:0 |
| pin_drive_low | output | 4*NIB | Open-drain pull-low enable for each pin |
| pin_pullup | output | 4*NIB | Pull-up enable for each pin |
| standby | input | 1 | System is in standby |
| wake_req | output | 1 | Request to leave standby |

## Verification
Latch and direction writes take effect on the first rising edge after the strobe. Drive-low, pull-up and read-back values are therefore checked half a cycle after that edge. A pin change reaches dm_rdata only after the second rising edge, so the bench checks that the old value is still present after one edge and the new value after two. The wake request follows the synchronised pins with no further flop and drops in the same cycle that standby falls. The hold is set one edge after the live condition appears, so the bench checks the hold only after the pin has been released for two edges. A behavioural model in the bench keeps its own two-stage pin history and compares every output half a cycle after each falling edge. The bench drives inputs on the falling edge, so every comparison reads values that have settled.

// File: rtl/kmp_pkg.sv
package kmp_pkg;
   localparam int unsigned NIB    = 4;
   localparam int unsigned NPORT  = 4;
   localparam int unsigned BANK_W = 2;
   localparam int unsigned DM_AW  = 7;
   localparam int unsigned RF_AW  = 6;

   // data-memory addresses: port k sits at ADR_PORT0 + k
   localparam int unsigned ADR_PORT0 = 'h70;
   // register-file addresses
   localparam int unsigned ADR_BDIR  = 'h26;
   localparam int unsigned ADR_CDDIR = 'h37;
   localparam int unsigned CDIR_BIT  = 2;
   localparam int unsigned DDIR_BIT  = 3;

   typedef enum logic [1:0] {
      DIR_INPUT_ONLY = 2'd0,
      DIR_PER_BIT    = 2'd1,
      DIR_GROUP      = 2'd2
   } dir_mode_e;

   // direction scheme of each port, index 0 .. 3
   function automatic dir_mode_e port_mode(input int unsigned idx);
      case (idx)
         0:       return DIR_INPUT_ONLY;
         1:       return DIR_PER_BIT;
         default: return DIR_GROUP;
      endcase
   endfunction
endpackage

// File: rtl/kmp_sync.sv
module kmp_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("kmp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stage[i] <= '1;
      end else begin
         stage[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stage[i] <= stage[i-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/kmp_dirctl.sv
module kmp_dirctl #(
   parameter int unsigned NIB   = kmp_pkg::NIB,
   parameter int unsigned RF_AW = kmp_pkg::RF_AW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RF_AW-1:0] rf_addr,
   input  logic             rf_wr,
   input  logic [NIB-1:0]   rf_wdata,
   output logic [NIB-1:0]   rf_rdata,
   output logic [NIB-1:0]   dir_b,
   output logic             dir_c,
   output logic             dir_d
);
   import kmp_pkg::*;

   localparam logic [RF_AW-1:0] A_B  = RF_AW'(ADR_BDIR);
   localparam logic [RF_AW-1:0] A_CD = RF_AW'(ADR_CDDIR);

   if (CDIR_BIT >= NIB || DDIR_BIT >= NIB || CDIR_BIT == DDIR_BIT) begin : g_bad_bits
      $error("kmp_dirctl: group direction bits must be distinct and inside the nibble");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_b <= '0;
         dir_c <= 1'b1;
         dir_d <= 1'b1;
      end else if (rf_wr) begin
         if (rf_addr == A_B) dir_b <= rf_wdata;
         if (rf_addr == A_CD) begin
            dir_c <= rf_wdata[CDIR_BIT];
            dir_d <= rf_wdata[DDIR_BIT];
         end
      end
   end

   always_comb begin
      rf_rdata = '0;
      if (rf_addr == A_B) begin
         rf_rdata = dir_b;
      end else if (rf_addr == A_CD) begin
         rf_rdata[CDIR_BIT] = dir_c;
         rf_rdata[DDIR_BIT] = dir_d;
      end
   end
endmodule

// File: rtl/kmp_port.sv
module kmp_port #(
   parameter int unsigned NIB = kmp_pkg::NIB
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [NIB-1:0] wdata,
   input  logic [NIB-1:0] dir_out,
   input  logic [NIB-1:0] pin_sync,
   output logic [NIB-1:0] rd_val,
   output logic [NIB-1:0] drive_low,
   output logic [NIB-1:0] pull_en
);
   logic [NIB-1:0] latch_q;

   // the latch is written whatever the direction
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     latch_q <= '0;
      else if (wr_en) latch_q <= wdata;
   end

   assign rd_val    = (dir_out & latch_q) | (~dir_out & pin_sync);
   assign drive_low = dir_out & ~latch_q;
   assign pull_en   = ~dir_out;
endmodule

// File: rtl/kmp_wake.sv
module kmp_wake #(
   parameter int unsigned PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          standby,
   input  logic [PW-1:0] pin_sync,
   input  logic [PW-1:0] in_mode,
   output logic          wake_req
);
   logic live, held;

   assign live = |(in_mode & ~pin_sync);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        held <= 1'b0;
      else if (!standby) held <= 1'b0;
      else if (live)     held <= 1'b1;
   end

   assign wake_req = standby & (live | held);
endmodule

// File: rtl/keymx_port_bank.sv
module keymx_port_bank #(
   parameter int unsigned NIB         = kmp_pkg::NIB,
   parameter int unsigned BANK_W      = kmp_pkg::BANK_W,
   parameter int unsigned DM_AW       = kmp_pkg::DM_AW,
   parameter int unsigned RF_AW       = kmp_pkg::RF_AW,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [BANK_W-1:0]       dm_bank,
   input  logic [DM_AW-1:0]        dm_addr,
   input  logic                    dm_wr,
   input  logic [NIB-1:0]          dm_wdata,
   output logic [NIB-1:0]          dm_rdata,
   input  logic [RF_AW-1:0]        rf_addr,
   input  logic                    rf_wr,
   input  logic [NIB-1:0]          rf_wdata,
   output logic [NIB-1:0]          rf_rdata,
   input  logic [4*NIB-1:0]        pin_in,
   output logic [4*NIB-1:0]        pin_drive_low,
   output logic [4*NIB-1:0]        pin_pullup,
   input  logic                    standby,
   output logic                    wake_req
);
   import kmp_pkg::*;

   localparam int unsigned NP = NPORT;
   localparam int unsigned PW = NP * NIB;

   if (NIB < 4) begin : g_bad_nib
      $error("keymx_port_bank: NIB must be at least 4");
   end
   if ((1 << DM_AW) <= ADR_PORT0 + NP - 1) begin : g_bad_dmaw
      $error("keymx_port_bank: DM_AW too narrow for port addresses");
   end

   logic [PW-1:0]  pin_sync;
   logic [NIB-1:0] dir_b;
   logic           dir_c, dir_d;
   logic [NIB-1:0] dir_vec [NP];
   logic [NIB-1:0] rd_val  [NP];
   logic [PW-1:0]  in_mode;
   logic           bank0;

   assign bank0 = (dm_bank == '0);

   kmp_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   kmp_dirctl #(.NIB(NIB), .RF_AW(RF_AW)) u_dir (
      .clk(clk), .rst_n(rst_n),
      .rf_addr(rf_addr), .rf_wr(rf_wr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
      .dir_b(dir_b), .dir_c(dir_c), .dir_d(dir_d)
   );

   for (genvar p = 0; p < int'(NP); p++) begin : g_port
      localparam dir_mode_e MODE = port_mode(p);
      localparam logic [DM_AW-1:0] MY_ADR = DM_AW'(ADR_PORT0 + p);
      logic [NIB-1:0] nib_sync;
      assign nib_sync = pin_sync[p*NIB +: NIB];

      if (MODE == DIR_INPUT_ONLY) begin : g_in
         assign dir_vec[p]                 = '0;
         assign rd_val[p]                  = nib_sync;
         assign pin_drive_low[p*NIB +: NIB] = '0;
         assign pin_pullup[p*NIB +: NIB]    = '1;
      end else begin : g_io
         logic wr_en;
         assign wr_en = dm_wr & bank0 & (dm_addr == MY_ADR);
         if (MODE == DIR_PER_BIT) begin : g_bit
            assign dir_vec[p] = dir_b;
         end else begin : g_grp
            assign dir_vec[p] = {NIB{(p == 2) ? dir_c : dir_d}};
         end
         kmp_port #(.NIB(NIB)) u_port (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en), .wdata(dm_wdata),
            .dir_out(dir_vec[p]), .pin_sync(nib_sync),
            .rd_val(rd_val[p]),
            .drive_low(pin_drive_low[p*NIB +: NIB]),
            .pull_en(pin_pullup[p*NIB +: NIB])
         );
      end
      assign in_mode[p*NIB +: NIB] = ~dir_vec[p];
   end

   always_comb begin
      dm_rdata = '0;
      if (bank0) begin
         for (int p = 0; p < int'(NP); p++) begin
            if (dm_addr == DM_AW'(ADR_PORT0 + p)) dm_rdata = rd_val[p];
         end
      end
   end

   kmp_wake #(.PW(PW)) u_wake (
      .clk(clk), .rst_n(rst_n), .standby(standby),
      .pin_sync(pin_sync), .in_mode(in_mode), .wake_req(wake_req)
   );
endmodule

// File: rtl/kmp_checker.sv
module kmp_checker #(
   parameter int unsigned NIB    = 4,
   parameter int unsigned BANK_W = 2,
   parameter int unsigned DM_AW  = 7,
   parameter int unsigned RF_AW  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BANK_W-1:0] dm_bank,
   input logic [DM_AW-1:0]  dm_addr,
   input logic              dm_wr,
   input logic [NIB-1:0]    dm_wdata,
   input logic [RF_AW-1:0]  rf_addr,
   input logic              rf_wr,
   input logic [NIB-1:0]    rf_wdata,
   input logic [4*NIB-1:0]  pin_drive_low,
   input logic [4*NIB-1:0]  pin_pullup,
   input logic              standby,
   input logic              wake_req
);
   localparam logic [DM_AW-1:0] A_PC = DM_AW'(kmp_pkg::ADR_PORT0 + 2);
   localparam logic [RF_AW-1:0] A_BD = RF_AW'(kmp_pkg::ADR_BDIR);

   AST_PORTA_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_drive_low[NIB-1:0] == '0) && (pin_pullup[NIB-1:0] == '1)); // R1

   AST_BDIR_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr && rf_addr == A_BD) |=> (pin_pullup[2*NIB-1:NIB] == ~$past(rf_wdata))); // R3

   AST_LATCH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_wr && dm_bank == '0 && dm_addr == A_PC) |=>
      (pin_drive_low[3*NIB-1:2*NIB] == (~$past(dm_wdata) & ~pin_pullup[3*NIB-1:2*NIB]))); // R5

   AST_OD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_drive_low & pin_pullup) == '0); // R6

   AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !standby |-> !wake_req); // R10

   AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (standby && $past(standby) && $past(wake_req)) |-> wake_req); // R10
endmodule

bind keymx_port_bank kmp_checker #(
   .NIB(NIB), .BANK_W(BANK_W), .DM_AW(DM_AW), .RF_AW(RF_AW)
) u_chk (.*);

// File: tb/sim_keymx_port_bank.sv
`timescale 1ns/1ps
module sim_keymx_port_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  dm_bank = '0;
   logic [6:0]  dm_addr = 7'h70;
   logic        dm_wr = 1'b0;
   logic [3:0]  dm_wdata = '0;
   logic [3:0]  dm_rdata;
   logic [5:0]  rf_addr = 6'h00;
   logic        rf_wr = 1'b0;
   logic [3:0]  rf_wdata = '0;
   logic [3:0]  rf_rdata;
   logic [15:0] pin_in = 16'hFFFF;
   logic [15:0] pin_drive_low, pin_pullup;
   logic        standby = 1'b0;
   logic        wake_req;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   keymx_port_bank u0 (.*);

   // ---- behavioural reference ----
   logic [15:0] m_s1 = 16'hFFFF, m_s2 = 16'hFFFF;
   logic [3:0]  m_lat [1:3];
   logic [3:0]  m_bdir = 4'h0;
   logic        m_cdir = 1'b1, m_ddir = 1'b1, m_hold = 1'b0;

   function automatic logic [15:0] m_dir();
      return {{4{m_ddir}}, {4{m_cdir}}, m_bdir, 4'h0};
   endfunction
   function automatic logic [15:0] m_latv();
      return {m_lat[3], m_lat[2], m_lat[1], 4'h0};
   endfunction
   function automatic logic m_live();
      return |(~m_dir() & ~m_s2);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 16'hFFFF; m_s2 <= 16'hFFFF;
         for (int k = 1; k <= 3; k++) m_lat[k] <= 4'h0;
         m_bdir <= 4'h0; m_cdir <= 1'b1; m_ddir <= 1'b1; m_hold <= 1'b0;
      end else begin
         m_s1 <= pin_in; m_s2 <= m_s1;
         if (dm_wr && dm_bank == 2'd0 && dm_addr >= 7'h71 && dm_addr <= 7'h73)
            m_lat[int'(dm_addr) - 'h70] <= dm_wdata;
         if (rf_wr && rf_addr == 6'h26) m_bdir <= rf_wdata;
         if (rf_wr && rf_addr == 6'h37) begin m_cdir <= rf_wdata[2]; m_ddir <= rf_wdata[3]; end
         m_hold <= standby ? (m_hold | m_live()) : 1'b0;
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         logic [15:0] d, rv;
         logic [3:0]  er, ef;
         d  = m_dir();
         rv = (d & m_latv()) | (~d & m_s2);
         er = 4'h0;
         if (dm_bank == 2'd0 && dm_addr >= 7'h70 && dm_addr <= 7'h73)
            er = rv[(int'(dm_addr) - 'h70)*4 +: 4];
         ef = (rf_addr == 6'h26) ? m_bdir : (rf_addr == 6'h37) ? {m_ddir, m_cdir, 2'b00} : 4'h0;
         check("R5 drive_low", pin_drive_low, d & ~m_latv());
         check("R6 pullup", pin_pullup, ~d);
         check("R7/R9 dm_rdata", {12'h0, dm_rdata}, {12'h0, er});
         check("R3/R4 rf_rdata", {12'h0, rf_rdata}, {12'h0, ef});
         check("R10 wake_req", {15'h0, wake_req}, {15'h0, standby & (m_live() | m_hold)});
      end
   end

   task automatic tick(); @(posedge clk); @(negedge clk); endtask
   task automatic dmw(input logic [1:0] b, input logic [6:0] a, input logic [3:0] v);
      dm_bank = b; dm_addr = a; dm_wdata = v; dm_wr = 1'b1; tick(); dm_wr = 1'b0; dm_bank = 2'd0;
   endtask
   task automatic rfw(input logic [5:0] a, input logic [3:0] v);
      rf_addr = a; rf_wdata = v; rf_wr = 1'b1; tick(); rf_wr = 1'b0;
   endtask

   initial begin
      #1_000_000;
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick(); #2;
      // R8 reset state
      check("R8 reset drive_low", pin_drive_low, 16'hFF00);
      check("R8 reset pullup", pin_pullup, 16'h00FF);
      rf_addr = 6'h37; #0.1;
      check("R4 reset rf 0x37", {12'h0, rf_rdata}, 16'h000C);
      @(negedge clk);
      // R1 write to input-only port has no effect
      dmw(2'd0, 7'h70, 4'h0); #2;
      check("R1 porta drive", {12'h0, pin_drive_low[3:0]}, 16'h0000);
      check("R1 porta pullup", {12'h0, pin_pullup[3:0]}, 16'h000F);
      @(negedge clk);
      // R2 write in bank 1 ignored
      dmw(2'd1, 7'h72, 4'hF); #2;
      check("R2 bank1 ignored", {8'h0, pin_drive_low[11:8]}, 16'h000F);
      @(negedge clk);
      dmw(2'd0, 7'h72, 4'h6); #2;
      check("R2 portc write", {12'h0, pin_drive_low[11:8]}, 16'h0009);
      @(negedge clk);
      dm_addr = 7'h72; #0.1;
      check("R7 read latch", {12'h0, dm_rdata}, 16'h0006);
      @(negedge clk);
      // R11 latch written in input mode, then output selected
      dmw(2'd0, 7'h71, 4'hA); #2;
      check("R11 no drive in input", {12'h0, pin_drive_low[7:4]}, 16'h0000);
      @(negedge clk);
      rfw(6'h26, 4'b0101); #2;
      check("R3 per-bit drive", {12'h0, pin_drive_low[7:4]}, 16'h0005);
      check("R3 per-bit pullup", {12'h0, pin_pullup[7:4]}, 16'h000A);
      @(negedge clk);
      rfw(6'h26, 4'hF); #2;
      check("R11 stored latch drives", {12'h0, pin_drive_low[7:4]}, 16'h0005);
      @(negedge clk);
      // R4 group direction: port C input, port D stays output
      rfw(6'h37, 4'b1000); #2;
      check("R4 group C input", {8'h0, pin_pullup[15:8]}, 16'h000F);
      @(negedge clk);
      // R9 two-edge sync latency on port A
      dm_addr = 7'h70; pin_in[3:0] = 4'h3;
      tick(); #2;
      check("R9 one edge old", {12'h0, dm_rdata}, 16'h000F);
      tick(); #2;
      check("R9 two edges new", {12'h0, dm_rdata}, 16'h0003);
      @(negedge clk);
      pin_in[3:0] = 4'hF;
      rfw(6'h26, 4'h0);
      tick(); tick();
      // R10 wake on input low while in standby, held after release
      standby = 1'b1; pin_in[4] = 1'b0;
      tick(); #2;
      check("R10 not yet", {15'h0, wake_req}, 16'h0000);
      tick(); #2;
      check("R10 wake raised", {15'h0, wake_req}, 16'h0001);
      @(negedge clk);
      pin_in[4] = 1'b1;
      tick(); tick(); tick(); #2;
      check("R10 wake held", {15'h0, wake_req}, 16'h0001);
      @(negedge clk);
      standby = 1'b0; #2;
      check("R10 wake cleared", {15'h0, wake_req}, 16'h0000);
      @(negedge clk);
      // R10 output-mode pins low do not wake
      standby = 1'b1; rfw(6'h37, 4'hC); pin_in[15:8] = 8'h00;
      tick(); tick(); tick(); #2;
      check("R10 output pins ignored", {15'h0, wake_req}, 16'h0000);
      @(negedge clk);
      standby = 1'b0; pin_in = 16'hFFFF;
      // varied traffic compared every cycle by the model
      for (int i = 0; i < 40; i++) begin
         dm_addr = 7'h70 + 7'(i % 5);
         rf_addr = (i % 3 == 0) ? 6'h26 : 6'h37;
         pin_in = 16'(i * 16'h3b1d);
         standby = i[2];
         if (i % 4 == 1) dmw(2'(i % 2), 7'h71 + 7'(i % 3), 4'(i * 7));
         else if (i % 4 == 3) rfw(rf_addr, 4'(i * 5));
         else tick();
      end
      tick(); tick();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule